// File: doc/BRIEF.md
# Gated Frequency-Offset Correction Loop

This block accumulates signed frequency-error samples from a demodulator into a signed correction word. The word retunes a fractional-N synthesizer: it is added to the nominal frequency so that the detected offset is cancelled. The same word is the value that a frequency-offset register reads back. Its configuration comes from one 8-bit control byte, a band select and a 9-bit deviation setting.

During the preamble the loop tracks the offset. When a preamble is detected it holds its value for the rest of the packet. In multi-packet operation a packet-end pulse clears the loop so that it acquires the offset again for the next packet. A runaway guard returns the correction to zero when its magnitude passes a limit. That limit depends on the band and on the deviation, and a control bit halves it. When the loop is disabled, the output carries a static offset instead, and the loop state does not change.

Top module: `afc_offset_ctrl`

## Requirements
- R1: After reset the accumulator is zero and the loop is not frozen, so `corr_o` reads 0 and `frozen_o` reads 0 when the loop is enabled.
- R2: The control byte `ctrl_i` is decoded as follows: bit 7 halves the runaway limit, bit 6 enables the loop, bits 5:3 are the acquisition shift and bits 2:0 are the tracking shift. The default value 0x40 means the loop is enabled and both shifts are zero. With bit 6 set, `corr_o` shows the accumulator. With bit 6 clear, `corr_o` shows `static_ofs_i` sign-extended to the width of `corr_o`.
- R3: Each valid error sample that arrives while the loop is enabled and not frozen is shifted arithmetically right and then added to the accumulator. The first GEAR_SAMPLES accepted samples after reset or after a packet clear use the acquisition shift (bits 5:3). Later samples use the tracking shift (bits 2:0). The result appears on `corr_o` one clock later.
- R4: A preamble-detect pulse while the loop is enabled sets `frozen_o` on the next clock. The pulse discards any sample in the same cycle. While the loop is frozen, samples are ignored and the accumulator holds.
- R5: A packet-end pulse with `multi_pkt_i` high clears the accumulator, the freeze flag and the gear count. This clear takes precedence over a sample or a preamble pulse in the same cycle. With `multi_pkt_i` low, a packet-end pulse has no effect.
- R6: If the magnitude of the updated accumulator exceeds the limit, the accumulator becomes zero instead. The limit is twice `dev_i` when `high_band_i` is 1 and `dev_i` itself when `high_band_i` is 0. The comparison is strictly greater than.
- R7: When `ctrl_i` bit 7 is set, the limit of R6 is halved by a right shift of one bit.
- R8: The accumulator saturates at its signed range and never wraps.
- R9: While `ctrl_i` bit 6 is clear, samples and preamble and packet-end pulses change nothing. The accumulator and `frozen_o` hold, and they are seen unchanged once the loop is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Control byte (halve, enable, acquisition shift, tracking shift) |
| high_band_i | input | 1 | 1 selects the high-band limit (twice the deviation) |
| dev_i | input | DEV_W | Deviation setting |
| static_ofs_i | input | OFS_W | Static offset, signed |
| err_valid_i | input | 1 | Error sample strobe |
| err_i | input | ERR_W | Signed frequency-error sample |
| preamble_det_i | input | 1 | Preamble-detect pulse |
| pkt_end_i | input | 1 | Packet-end pulse |
| multi_pkt_i | input | 1 | Multi-packet mode |
| corr_o | output | OFS_W+GUARD_W | Signed correction for the synthesizer and for readback |
| frozen_o | output | 1 | Loop is frozen |

## Verification
The bench builds the block with GUARD_W=0, which makes the accumulator 10 bits wide. With that width the deviation limit (up to 1022) lies above the saturation bound (511), so R8 saturation can be reached at both ends without the runaway guard firing first. GEAR_SAMPLES=4 means that the change from the acquisition shift to the tracking shift happens within a few samples after each reset or packet clear. A behavioural model follows every clock through directed phases, and then through a long random phase that mixes the pulses, the band, the deviation, the control byte and the samples.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int GEAR_W = 3;

  typedef struct packed {
    logic              halve;
    logic              en;
    logic [GEAR_W-1:0] gear_hi;
    logic [GEAR_W-1:0] gear_lo;
  } afc_ctrl_t;
endpackage

// File: rtl/afc_gear.sv
module afc_gear #(
  parameter int ERR_W        = 10,
  parameter int OUT_W        = 13,
  parameter int GEAR_SAMPLES = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic                          step_i,
  input  logic signed [ERR_W-1:0]       err_i,
  input  logic [afc_pkg::GEAR_W-1:0]    gear_hi_i,
  input  logic [afc_pkg::GEAR_W-1:0]    gear_lo_i,
  output logic signed [OUT_W-1:0]       scaled_o
);
  localparam int CNT_W = $clog2(GEAR_SAMPLES + 1);

  logic [CNT_W-1:0]              cnt_q;
  logic                          acq;
  logic [afc_pkg::GEAR_W-1:0]    shift;
  logic signed [OUT_W-1:0]       err_x;

  assign acq   = cnt_q < CNT_W'(GEAR_SAMPLES);
  assign shift = acq ? gear_hi_i : gear_lo_i;
  assign err_x = OUT_W'(err_i);
  assign scaled_o = err_x >>> shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (step_i && acq)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/afc_limit.sv
module afc_limit #(
  parameter int DEV_W = 9
) (
  input  logic [DEV_W-1:0] dev_i,
  input  logic             high_band_i,
  input  logic             halve_i,
  output logic [DEV_W:0]   limit_o
);
  logic [DEV_W:0] base;

  assign base    = high_band_i ? {dev_i, 1'b0} : {1'b0, dev_i};
  assign limit_o = halve_i ? (base >> 1) : base;
endmodule

// File: rtl/afc_accum.sv
module afc_accum #(
  parameter int ACC_W = 12,
  parameter int LIM_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    step_i,
  input  logic signed [ACC_W:0]   inc_i,
  input  logic [LIM_W-1:0]        limit_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int CMP_W = (ACC_W + 1 > LIM_W) ? ACC_W + 1 : LIM_W;
  localparam logic signed [ACC_W:0] SAT_MAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] SAT_MIN = {2'b11, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, sat_v;
  logic signed [ACC_W:0]   sum, ext;
  logic [ACC_W:0]          mag;
  logic                    runaway;

  assign sum = $signed({acc_q[ACC_W-1], acc_q}) + inc_i;

  always_comb begin
    if (sum > SAT_MAX)      sat_v = SAT_MAX[ACC_W-1:0];
    else if (sum < SAT_MIN) sat_v = SAT_MIN[ACC_W-1:0];
    else                    sat_v = sum[ACC_W-1:0];
  end

  assign ext     = $signed({sat_v[ACC_W-1], sat_v});
  assign mag     = ext[ACC_W] ? unsigned'(-ext) : unsigned'(ext);
  assign runaway = CMP_W'(mag) > CMP_W'(limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= runaway ? '0 : sat_v;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/afc_offset_ctrl.sv
module afc_offset_ctrl #(
  parameter int ERR_W        = 10,
  parameter int OFS_W        = 10,
  parameter int GUARD_W      = 2,
  parameter int DEV_W        = 9,
  parameter int GEAR_SAMPLES = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [7:0]                    ctrl_i,
  input  logic                          high_band_i,
  input  logic [DEV_W-1:0]              dev_i,
  input  logic signed [OFS_W-1:0]       static_ofs_i,
  input  logic                          err_valid_i,
  input  logic signed [ERR_W-1:0]       err_i,
  input  logic                          preamble_det_i,
  input  logic                          pkt_end_i,
  input  logic                          multi_pkt_i,
  output logic signed [OFS_W+GUARD_W-1:0] corr_o,
  output logic                          frozen_o
);
  localparam int ACC_W = OFS_W + GUARD_W;
  localparam int LIM_W = DEV_W + 1;

  afc_pkg::afc_ctrl_t     ctrl;
  logic                   clear, step, frz_q;
  logic signed [ACC_W:0]  inc;
  logic [LIM_W-1:0]       limit;
  logic signed [ACC_W-1:0] acc, st_x;

  assign ctrl  = afc_pkg::afc_ctrl_t'(ctrl_i);
  // packet clear wins over sample and preamble
  assign clear = ctrl.en && multi_pkt_i && pkt_end_i;
  assign step  = ctrl.en && !clear && !preamble_det_i && !frz_q && err_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         frz_q <= 1'b0;
    else if (clear)                      frz_q <= 1'b0;
    else if (ctrl.en && preamble_det_i)  frz_q <= 1'b1;
  end

  afc_gear #(
    .ERR_W       (ERR_W),
    .OUT_W       (ACC_W + 1),
    .GEAR_SAMPLES(GEAR_SAMPLES)
  ) u_gear (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .step_i    (step),
    .err_i     (err_i),
    .gear_hi_i (ctrl.gear_hi),
    .gear_lo_i (ctrl.gear_lo),
    .scaled_o  (inc)
  );

  afc_limit #(.DEV_W(DEV_W)) u_limit (
    .dev_i       (dev_i),
    .high_band_i (high_band_i),
    .halve_i     (ctrl.halve),
    .limit_o     (limit)
  );

  afc_accum #(.ACC_W(ACC_W), .LIM_W(LIM_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .step_i  (step),
    .inc_i   (inc),
    .limit_i (limit),
    .acc_o   (acc)
  );

  assign st_x     = ACC_W'(static_ofs_i);
  assign corr_o   = ctrl.en ? acc : st_x;
  assign frozen_o = frz_q;
endmodule

// File: rtl/afc_offset_chk.sv
module afc_offset_chk #(
  parameter int ACC_W = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [7:0]              ctrl_i,
  input logic                    preamble_det_i,
  input logic                    pkt_end_i,
  input logic                    multi_pkt_i,
  input logic signed [ACC_W-1:0] corr_o,
  input logic                    frozen_o
);
  // R4
  freeze_on_preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && preamble_det_i && !(multi_pkt_i && pkt_end_i)) |=> frozen_o);

  // R4
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && frozen_o && !(multi_pkt_i && pkt_end_i)) |=> (!ctrl_i[6] || $stable(corr_o)));

  // R5
  pkt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && multi_pkt_i && pkt_end_i) |=> (!frozen_o && (!ctrl_i[6] || corr_o == '0)));

  // R9
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[6] |=> $stable(frozen_o));
endmodule

bind afc_offset_ctrl afc_offset_chk #(.ACC_W(OFS_W + GUARD_W)) u_chk (.*);

// File: tb/sim_afc_offset_ctrl.sv
`timescale 1ns/1ps
module sim_afc_offset_ctrl;
  localparam int ERR_W = 10, OFS_W = 10, GUARD_W = 0, DEV_W = 9, GEAR_SAMPLES = 4;
  localparam int ACC_W = OFS_W + GUARD_W;
  localparam int SMAX = (1 << (ACC_W - 1)) - 1;
  localparam int SMIN = -(1 << (ACC_W - 1));

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] ctrl_i = 8'h40;
  logic high_band_i = 1'b1;
  logic [DEV_W-1:0] dev_i = '0;
  logic signed [OFS_W-1:0] static_ofs_i = '0;
  logic err_valid_i = 1'b0;
  logic signed [ERR_W-1:0] err_i = '0;
  logic preamble_det_i = 1'b0, pkt_end_i = 1'b0, multi_pkt_i = 1'b0;
  logic signed [ACC_W-1:0] corr_o;
  logic frozen_o;

  always #2.5 clk_i = ~clk_i;

  afc_offset_ctrl #(.ERR_W(ERR_W), .OFS_W(OFS_W), .GUARD_W(GUARD_W), .DEV_W(DEV_W),
                    .GEAR_SAMPLES(GEAR_SAMPLES)) u0 (.*);

  int errors = 0, checks = 0;
  int m_acc = 0, m_cnt = 0;
  bit m_frz = 1'b0, done = 1'b0;
  string tag = "R1";

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int lim, inc, s, sh;
    if (!ctrl_i[6]) return;
    if (multi_pkt_i && pkt_end_i) begin
      m_acc = 0; m_frz = 1'b0; m_cnt = 0;
    end else if (preamble_det_i) begin
      m_frz = 1'b1;
    end else if (!m_frz && err_valid_i) begin
      sh  = (m_cnt < GEAR_SAMPLES) ? int'(ctrl_i[5:3]) : int'(ctrl_i[2:0]);
      inc = int'(err_i) >>> sh;
      s   = m_acc + inc;
      if (s > SMAX) s = SMAX;
      if (s < SMIN) s = SMIN;
      lim = high_band_i ? 2 * int'(dev_i) : int'(dev_i);
      if (ctrl_i[7]) lim = lim >> 1;
      m_acc = ((s < 0 ? -s : s) > lim) ? 0 : s;
      if (m_cnt < GEAR_SAMPLES) m_cnt++;
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk("corr_o", int'(corr_o), ctrl_i[6] ? m_acc : int'(static_ofs_i));
    chk("frozen_o", int'(frozen_o), int'(m_frz));
  endtask

  task automatic sample(int e);
    err_valid_i = 1'b1; err_i = ERR_W'(e);
    cyc();
    err_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    tag = "R1";
    chk("corr_o in reset", int'(corr_o), 0);
    rst_ni = 1'b1;
    cyc();
    chk("frozen_o after reset", int'(frozen_o), 0);

    // R3: acquisition shift 2 for 4 samples, then tracking shift 0
    tag = "R3"; high_band_i = 1'b1; dev_i = 9'd400; ctrl_i = 8'b0101_0000;
    repeat (4) sample(40);
    sample(40); sample(-13); sample(-7);
    cyc();

    // R4: preamble with sample in the same cycle, then samples ignored
    tag = "R4"; preamble_det_i = 1'b1; sample(30); preamble_det_i = 1'b0;
    sample(50); sample(-90); cyc();

    // R5: packet end outside multi mode ignored, then clear with sample
    tag = "R5"; pkt_end_i = 1'b1; cyc(); pkt_end_i = 1'b0;
    multi_pkt_i = 1'b1; pkt_end_i = 1'b1; preamble_det_i = 1'b1; sample(100);
    pkt_end_i = 1'b0; preamble_det_i = 1'b0;
    sample(12);

    // R6: low band limit = dev
    tag = "R6"; pkt_end_i = 1'b1; cyc(); pkt_end_i = 1'b0;
    ctrl_i = 8'h40; high_band_i = 1'b0; dev_i = 9'd50;
    sample(20); sample(30); sample(1); sample(25); sample(25); sample(-50); sample(-1);

    // R7: halved high band limit = dev
    tag = "R7"; pkt_end_i = 1'b1; cyc(); pkt_end_i = 1'b0;
    ctrl_i = 8'hC0; high_band_i = 1'b1; dev_i = 9'd50;
    sample(30); sample(20); sample(1); sample(-40);

    // R8: saturation at both ends, limit above range
    tag = "R8"; ctrl_i = 8'h40; dev_i = 9'd511;
    repeat (3) sample(300);
    repeat (5) sample(-400);

    // R9: disabled, all controls ignored
    tag = "R9"; ctrl_i = 8'h00; static_ofs_i = -10'sd77;
    sample(100); preamble_det_i = 1'b1; cyc(); preamble_det_i = 1'b0;
    pkt_end_i = 1'b1; cyc(); pkt_end_i = 1'b0;
    ctrl_i = 8'h40; cyc();

    // R2: readback mux with static offsets of both signs
    tag = "R2"; ctrl_i = 8'h00; static_ofs_i = 10'sd311; cyc();
    static_ofs_i = -10'sd512; cyc();
    ctrl_i = 8'h40; cyc();

    // random mix
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      ctrl_i        = 8'($urandom);
      ctrl_i[6]     = ($urandom_range(0, 7) != 0);
      high_band_i   = 1'($urandom);
      dev_i         = DEV_W'($urandom);
      static_ofs_i  = OFS_W'($urandom);
      multi_pkt_i   = 1'($urandom);
      preamble_det_i = ($urandom_range(0, 40) == 0);
      pkt_end_i     = ($urandom_range(0, 30) == 0);
      err_valid_i   = 1'($urandom);
      err_i         = ERR_W'($urandom);
      cyc();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule